// File: doc/BRIEF.md
# eMMC Card Bring-Up Sequencer

This block takes a freshly powered eMMC device from its idle state to a selected state that is ready for data transfer. It does this by driving a generic command port toward a lower-level command/response engine. The engine handles CRC, line serialisation and clock division. The sequencer does not. For each command it presents an opcode, a 32-bit argument and a response type, then waits for done or error. It reads 48-bit responses as a 32-bit payload and 136-bit responses as a 128-bit register image. It receives the 512-byte extended register as a byte stream. A few multi-cycle waits are needed during bring-up, and the block counts them itself.

One `start` pulse runs the whole flow:
- an operating-condition poll that identifies the card and checks its voltage window in the same exchange,
- identity read, address assignment and card-specific-data read,
- legacy clock raise and card select,
- bus-width switch and extended-register read,
- cache enable.

The results are held on status outputs until the next `start`. These are card type, capacity mode, voltage capability, relative address, sector count, bus width and clock choice. Any failure stops the flow in an error state, with a code and the failing step number.

Top module: `emmc_init_seq`

## Requirements
- R1: A `start` while `host_spi` is high ends at once in the error state with `err_code`=1 and `err_step`=0, and no command is issued.
- R2: The first step issues opcode 1 with response type 4. Its argument always has bit 30 set, has bit 7 set when `host_v18` is high, and has bits 23:15 set when `host_v33` is high. The step is reissued until response bit 31 reads 1.
- R3: After RETRY_MAX opcode-1 responses with bit 31 clear, the flow stops with `err_code`=3 and `err_step`=1.
- R4: The first successful poll response sets `is_mmc`. The final poll response sets `cap_1v8` from bit 7, `cap_3v` from any of bits 23:15 and `high_cap` from bit 30. When `host_v18` and bit 7 are both high, `sig_1v8_sel` rises and the next command waits at least DELAY_CYCLES cycles. Retries are also spaced by DELAY_CYCLES.
- R5: Commands are issued in this order: 1 (poll), 2, 3, 9, 7, 6 (width), 8, 6 (cache). Opcodes 3, 9 and 7 carry RCA in argument bits 31:16 with bits 15:0 zero. Response types are R2=3 for opcodes 2 and 9, R1=1 for opcodes 3 and 8, and R1b=2 for opcodes 7 and 6.
- R6: If bits 127:126 of the opcode-9 response are below 2, the flow stops with `err_code`=4 and `err_step`=4.
- R7: The speed byte is bits 103:96 of the opcode-9 response. A unit of 2 (bits 2:0) with multiplier 6 (bits 6:3) gives `clk_sel`=2. Unit 2 with multiplier 5 gives `clk_sel`=1. Any other value gives 0.
- R8: The width switch argument is 0x03B70200 when `host_bus8` and `lanes8` are both high, and `bus_width` then becomes 2. Otherwise it is 0x03B70100 when `host_bus4` is high, and `bus_width` becomes 1. With neither, opcode 6 is skipped and `bus_width` stays 0.
- R9: `sector_count` is extended-register bytes 212..215, little-endian. If any of bytes 249..252 is non-zero, a final opcode 6 with argument 0x03210100 is issued; otherwise it is skipped.
- R10: After an R1b command completes, no further command is issued while `busy` is high.
- R11: A `cmd_err` with `cmd_done` stops the flow with `err_code`=2 and `err_step` equal to the step. Steps are 1 poll, 2 identity, 3 address, 4 CSD, 6 select, 7 width, 8 extended read, 9 cache. No further command is issued.
- R12: `init_done` and `init_err` are never high together. The error code holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (idle, done or error state) |
| host_spi | input | 1 | Host is wired in SPI mode |
| host_v18 | input | 1 | Host supports 1.8 V signalling |
| host_v33 | input | 1 | Host supports 3.0/3.3 V |
| host_bus8 | input | 1 | Host supports 8 data lanes |
| host_bus4 | input | 1 | Host supports 4 data lanes |
| lanes8 | input | 1 | Eight lanes are physically wired |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_opcode | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_type | output | 3 | 0 none, 1 R1, 2 R1b, 3 R2, 4 R3 |
| cmd_done | input | 1 | Response received |
| cmd_err | input | 1 | Command failed (valid with cmd_done) |
| busy | input | 1 | Card busy after an R1b command |
| rsp_short | input | 32 | Payload of a 48-bit response |
| rsp_long | input | 128 | Register image of a 136-bit response |
| reg_byte_valid | input | 1 | Extended-register byte strobe |
| reg_byte | input | 8 | Extended-register byte, index 0 first |
| init_done | output | 1 | Card ready |
| init_err | output | 1 | Flow stopped on error |
| err_code | output | 3 | 0 none, 1 config, 2 command, 3 timeout, 4 unsupported |
| err_step | output | 4 | Step number that failed |
| is_mmc | output | 1 | Card answered the poll |
| high_cap | output | 1 | Sector addressing |
| cap_1v8 | output | 1 | Card supports 1.7-1.95 V |
| cap_3v | output | 1 | Card supports 2.7-3.6 V |
| sig_1v8_sel | output | 1 | Switch signalling to 1.8 V |
| clk_sel | output | 2 | 0 slow, 1 20 MHz, 2 26 MHz |
| rca | output | 16 | Assigned relative address |
| sector_count | output | 32 | Device sector count |
| bus_width | output | 2 | 0 one lane, 1 four, 2 eight |

## Verification
A command strobe appears in the cycle after the sequencer enters a step. The model serves it two cycles later with `cmd_done`. The following command is then due one cycle after `cmd_done`, or one cycle after `busy` falls, or one cycle after the 512th register byte. The bench model samples `cmd_valid` on every falling edge, including the one where it drops `cmd_done`, so that no strobe is missed. It logs each command with its cycle number, which lets the bench measure the 1.8 V settle gap and flag any strobe during `busy`. The status outputs are read only once `init_done` or `init_err` is seen on a falling edge. At that point every result register has already been written.

// File: rtl/emmc_init_pkg.sv
package emmc_init_pkg;

    typedef enum logic [3:0] {
        STEP_NONE   = 4'd0,
        STEP_OPCOND = 4'd1,
        STEP_CID    = 4'd2,
        STEP_RCA    = 4'd3,
        STEP_CSD    = 4'd4,
        STEP_CLK    = 4'd5,
        STEP_SELECT = 4'd6,
        STEP_WIDTH  = 4'd7,
        STEP_EXTREG = 4'd8,
        STEP_CACHE  = 4'd9
    } step_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ISSUE, PH_WAIT, PH_BUSY, PH_DATA, PH_DELAY, PH_DONE, PH_FAIL
    } phase_e;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0, RSP_R1 = 3'd1, RSP_R1B = 3'd2, RSP_R2 = 3'd3, RSP_R3 = 3'd4
    } rsp_e;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0, ERR_CONFIG = 3'd1, ERR_CMD = 3'd2, ERR_TIMEOUT = 3'd3, ERR_UNSUP = 3'd4
    } err_e;

    typedef enum logic [1:0] { BW_1 = 2'd0, BW_4 = 2'd1, BW_8 = 2'd2 } bw_e;

    typedef enum logic [1:0] { CLK_SLOW = 2'd0, CLK_20 = 2'd1, CLK_26 = 2'd2 } clk_e;

    typedef struct packed {
        logic [5:0]  opcode;
        logic [31:0] arg;
        rsp_e        rsp;
        logic        skip;
    } cmd_t;

    localparam int OCR_READY_BIT  = 31;
    localparam int OCR_SECTOR_BIT = 30;
    localparam int OCR_LOWV_BIT   = 7;
    localparam logic [31:0] OCR_HIGHV_MASK = 32'h00FF_8000;

    localparam logic [7:0] IDX_WIDTH = 8'd183;
    localparam logic [7:0] IDX_CACHE = 8'd33;

    // write-byte access to one extended-register index
    function automatic logic [31:0] switch_arg(input logic [7:0] idx, input logic [7:0] val);
        return {6'b0, 2'b11, idx, val, 8'h00};
    endfunction

    function automatic clk_e speed_to_clk(input logic [6:0] spd);
        if (spd[2:0] == 3'd2 && spd[6:3] == 4'd6) return CLK_26;
        if (spd[2:0] == 3'd2 && spd[6:3] == 4'd5) return CLK_20;
        return CLK_SLOW;
    endfunction

endpackage

// File: rtl/emmc_cmd_builder.sv
module emmc_cmd_builder
    import emmc_init_pkg::*;
#(
    parameter logic [15:0] RCA = 16'h0001
) (
    input  step_e step,
    input  logic  host_v18,
    input  logic  host_v33,
    input  logic  host_bus8,
    input  logic  host_bus4,
    input  logic  lanes8,
    input  logic  cache_nz,
    output cmd_t  cmd,
    output bw_e   width_sel
);
    logic [31:0] ocr_arg;

    always_comb begin
        ocr_arg = 32'h0;
        ocr_arg[OCR_SECTOR_BIT] = 1'b1;
        if (host_v18) ocr_arg[OCR_LOWV_BIT] = 1'b1;
        if (host_v33) ocr_arg = ocr_arg | OCR_HIGHV_MASK;
    end

    always_comb begin
        if (host_bus8 && lanes8) width_sel = BW_8;
        else if (host_bus4)      width_sel = BW_4;
        else                     width_sel = BW_1;
    end

    always_comb begin
        cmd.opcode = 6'd0;
        cmd.arg    = 32'h0;
        cmd.rsp    = RSP_NONE;
        cmd.skip   = 1'b1;
        case (step)
            STEP_OPCOND: begin
                cmd.opcode = 6'd1; cmd.arg = ocr_arg; cmd.rsp = RSP_R3; cmd.skip = 1'b0;
            end
            STEP_CID: begin
                cmd.opcode = 6'd2; cmd.rsp = RSP_R2; cmd.skip = 1'b0;
            end
            STEP_RCA: begin
                cmd.opcode = 6'd3; cmd.arg = {RCA, 16'h0}; cmd.rsp = RSP_R1; cmd.skip = 1'b0;
            end
            STEP_CSD: begin
                cmd.opcode = 6'd9; cmd.arg = {RCA, 16'h0}; cmd.rsp = RSP_R2; cmd.skip = 1'b0;
            end
            STEP_SELECT: begin
                cmd.opcode = 6'd7; cmd.arg = {RCA, 16'h0}; cmd.rsp = RSP_R1B; cmd.skip = 1'b0;
            end
            STEP_WIDTH: begin
                cmd.opcode = 6'd6;
                cmd.arg    = switch_arg(IDX_WIDTH, (width_sel == BW_8) ? 8'd2 : 8'd1);
                cmd.rsp    = RSP_R1B;
                cmd.skip   = (width_sel == BW_1);
            end
            STEP_EXTREG: begin
                cmd.opcode = 6'd8; cmd.rsp = RSP_R1; cmd.skip = 1'b0;
            end
            STEP_CACHE: begin
                cmd.opcode = 6'd6;
                cmd.arg    = switch_arg(IDX_CACHE, 8'd1);
                cmd.rsp    = RSP_R1B;
                cmd.skip   = !cache_nz;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/emmc_delay_timer.sv
module emmc_delay_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (kick) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == LAST) run <= 1'b0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/emmc_extreg_capture.sv
module emmc_extreg_capture #(
    parameter int NBYTES   = 512,
    parameter int SEC_LO   = 212,
    parameter int CACHE_LO = 249
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic [31:0] sector_count,
    output logic        cache_nz,
    output logic        complete
);
    localparam int CW = $clog2(NBYTES + 1);

    logic [CW-1:0] cnt;

    assign complete = (cnt == CW'(NBYTES));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt          <= '0;
            sector_count <= 32'h0;
            cache_nz     <= 1'b0;
        end else if (en && byte_valid && !complete) begin
            cnt <= cnt + 1'b1;
            for (int i = 0; i < 4; i++) begin
                if (cnt == CW'(SEC_LO + i))
                    sector_count[8*i +: 8] <= byte_data;
                if (cnt == CW'(CACHE_LO + i) && byte_data != 8'h00)
                    cache_nz <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/emmc_init_seq.sv
module emmc_init_seq
    import emmc_init_pkg::*;
#(
    parameter int          RETRY_MAX    = 1000,
    parameter int          DELAY_CYCLES = 1000000,
    parameter logic [15:0] RCA          = 16'h0001,
    parameter int          EXT_BYTES    = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         host_spi,
    input  logic         host_v18,
    input  logic         host_v33,
    input  logic         host_bus8,
    input  logic         host_bus4,
    input  logic         lanes8,
    output logic         cmd_valid,
    output logic [5:0]   cmd_opcode,
    output logic [31:0]  cmd_arg,
    output logic [2:0]   cmd_rsp_type,
    input  logic         cmd_done,
    input  logic         cmd_err,
    input  logic         busy,
    input  logic [31:0]  rsp_short,
    input  logic [127:0] rsp_long,
    input  logic         reg_byte_valid,
    input  logic [7:0]   reg_byte,
    output logic         init_done,
    output logic         init_err,
    output logic [2:0]   err_code,
    output logic [3:0]   err_step,
    output logic         is_mmc,
    output logic         high_cap,
    output logic         cap_1v8,
    output logic         cap_3v,
    output logic         sig_1v8_sel,
    output logic [1:0]   clk_sel,
    output logic [15:0]  rca,
    output logic [31:0]  sector_count,
    output logic [1:0]   bus_width
);
    localparam int AW = $clog2(RETRY_MAX + 1);
    localparam logic [AW-1:0] LAST_TRY = AW'(RETRY_MAX - 1);

    phase_e        phase;
    step_e         step;
    step_e         resume;
    logic [AW-1:0] attempts;
    logic [6:0]    speed;
    cmd_t          cmd;
    bw_e           width_sel;
    logic          cache_nz;
    logic          ext_complete;
    logic          timer_kick;
    logic          timer_expired;
    logic          start_ok;
    logic          ocr_ready;
    logic          need_delay;
    logic          unused_bits;

    assign unused_bits = ^{rsp_long[125:104], rsp_long[103], rsp_long[95:0],
                           rsp_short[29:24], rsp_short[14:8], rsp_short[6:0]};

    emmc_cmd_builder #(.RCA(RCA)) u_builder (
        .step(step), .host_v18(host_v18), .host_v33(host_v33),
        .host_bus8(host_bus8), .host_bus4(host_bus4), .lanes8(lanes8),
        .cache_nz(cache_nz), .cmd(cmd), .width_sel(width_sel)
    );

    emmc_delay_timer #(.CYCLES(DELAY_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .kick(timer_kick), .expired(timer_expired)
    );

    emmc_extreg_capture #(.NBYTES(EXT_BYTES)) u_capture (
        .clk(clk), .rst(rst),
        .clear(start_ok || (phase == PH_ISSUE && step == STEP_EXTREG)),
        .en(phase == PH_DATA), .byte_valid(reg_byte_valid), .byte_data(reg_byte),
        .sector_count(sector_count), .cache_nz(cache_nz), .complete(ext_complete)
    );

    assign start_ok     = start && (phase == PH_IDLE || phase == PH_DONE || phase == PH_FAIL);
    assign cmd_valid    = (phase == PH_ISSUE) && !cmd.skip;
    assign cmd_opcode   = cmd.opcode;
    assign cmd_arg      = cmd.arg;
    assign cmd_rsp_type = cmd.rsp;
    assign init_done    = (phase == PH_DONE);
    assign init_err     = (phase == PH_FAIL);

    assign ocr_ready  = rsp_short[OCR_READY_BIT];
    assign need_delay = ocr_ready ? (host_v18 && rsp_short[OCR_LOWV_BIT])
                                  : (attempts != LAST_TRY);
    assign timer_kick = (phase == PH_WAIT) && cmd_done && !cmd_err &&
                        (step == STEP_OPCOND) && need_delay;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            step        <= STEP_NONE;
            resume      <= STEP_NONE;
            attempts    <= '0;
            speed       <= 7'h0;
            err_code    <= ERR_NONE;
            err_step    <= 4'd0;
            is_mmc      <= 1'b0;
            high_cap    <= 1'b0;
            cap_1v8     <= 1'b0;
            cap_3v      <= 1'b0;
            sig_1v8_sel <= 1'b0;
            clk_sel     <= CLK_SLOW;
            rca         <= 16'h0;
            bus_width   <= BW_1;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE, PH_FAIL: begin
                    if (start_ok) begin
                        attempts    <= '0;
                        err_code    <= ERR_NONE;
                        err_step    <= 4'd0;
                        is_mmc      <= 1'b0;
                        high_cap    <= 1'b0;
                        cap_1v8     <= 1'b0;
                        cap_3v      <= 1'b0;
                        sig_1v8_sel <= 1'b0;
                        clk_sel     <= CLK_SLOW;
                        rca         <= 16'h0;
                        bus_width   <= BW_1;
                        if (host_spi) begin
                            phase    <= PH_FAIL;
                            step     <= STEP_NONE;
                            err_code <= ERR_CONFIG;
                        end else begin
                            phase <= PH_ISSUE;
                            step  <= STEP_OPCOND;
                        end
                    end
                end
                PH_ISSUE: begin
                    if (cmd.skip) begin
                        if (step == STEP_CLK) clk_sel <= speed_to_clk(speed);
                        if (step == STEP_CACHE) phase <= PH_DONE;
                        else                    step  <= step_e'(step + 4'd1);
                    end else begin
                        phase <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (cmd_done) begin
                        if (cmd_err) begin
                            phase    <= PH_FAIL;
                            err_code <= ERR_CMD;
                            err_step <= step;
                        end else begin
                            case (step)
                                STEP_OPCOND: begin
                                    is_mmc <= 1'b1;
                                    if (ocr_ready) begin
                                        cap_1v8  <= rsp_short[OCR_LOWV_BIT];
                                        cap_3v   <= |(rsp_short & OCR_HIGHV_MASK);
                                        high_cap <= rsp_short[OCR_SECTOR_BIT];
                                        if (need_delay) begin
                                            sig_1v8_sel <= 1'b1;
                                            resume      <= STEP_CID;
                                            phase       <= PH_DELAY;
                                        end else begin
                                            step  <= STEP_CID;
                                            phase <= PH_ISSUE;
                                        end
                                    end else if (attempts == LAST_TRY) begin
                                        phase    <= PH_FAIL;
                                        err_code <= ERR_TIMEOUT;
                                        err_step <= STEP_OPCOND;
                                    end else begin
                                        attempts <= attempts + 1'b1;
                                        resume   <= STEP_OPCOND;
                                        phase    <= PH_DELAY;
                                    end
                                end
                                STEP_CSD: begin
                                    if (rsp_long[127:126] < 2'd2) begin
                                        phase    <= PH_FAIL;
                                        err_code <= ERR_UNSUP;
                                        err_step <= STEP_CSD;
                                    end else begin
                                        speed <= rsp_long[102:96];
                                        step  <= STEP_CLK;
                                        phase <= PH_ISSUE;
                                    end
                                end
                                STEP_EXTREG: phase <= PH_DATA;
                                default: begin
                                    if (step == STEP_RCA) rca <= RCA;
                                    if (cmd.rsp == RSP_R1B) begin
                                        phase <= PH_BUSY;
                                    end else begin
                                        step  <= step_e'(step + 4'd1);
                                        phase <= PH_ISSUE;
                                    end
                                end
                            endcase
                        end
                    end
                end
                PH_BUSY: begin
                    if (!busy) begin
                        if (step == STEP_WIDTH) bus_width <= width_sel;
                        if (step == STEP_CACHE) begin
                            phase <= PH_DONE;
                        end else begin
                            step  <= step_e'(step + 4'd1);
                            phase <= PH_ISSUE;
                        end
                    end
                end
                PH_DATA: begin
                    if (ext_complete) begin
                        step  <= STEP_CACHE;
                        phase <= PH_ISSUE;
                    end
                end
                PH_DELAY: begin
                    if (timer_expired) begin
                        step  <= resume;
                        phase <= PH_ISSUE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/emmc_init_seq_chk.sv
module emmc_init_seq_chk #(
    parameter logic [15:0] RCA = 16'h0001
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        host_spi,
    input logic        busy,
    input logic        cmd_valid,
    input logic [5:0]  cmd_opcode,
    input logic [31:0] cmd_arg,
    input logic [2:0]  cmd_rsp_type,
    input logic        init_done,
    input logic        init_err,
    input logic [2:0]  err_code,
    input logic [1:0]  bus_width,
    input logic [2:0]  phase
);
    localparam logic [2:0] P_IDLE = 3'd0, P_BUSY = 3'd3, P_DONE = 3'd6, P_FAIL = 3'd7;

    logic accept;
    assign accept = start && (phase == P_IDLE || phase == P_DONE || phase == P_FAIL);

    // R1
    spi_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && host_spi) |=> (init_err && err_code == 3'd1 && !cmd_valid));

    // R2
    opcond_arg_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_opcode == 6'd1) |-> (cmd_arg[30] && cmd_rsp_type == 3'd4));

    // R5
    rca_field_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_opcode == 6'd3 || cmd_opcode == 6'd9 || cmd_opcode == 6'd7))
        |-> (cmd_arg == {RCA, 16'h0}));

    // R8
    width_code_chk: assert property (@(posedge clk) disable iff (rst)
        bus_width != 2'd3);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == P_BUSY && busy) |=> (phase == P_BUSY && !cmd_valid));

    // R11
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R12
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(init_done && init_err));

    // R12
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (init_err && !start) |=> (init_err && $stable(err_code)));
endmodule

bind emmc_init_seq emmc_init_seq_chk #(.RCA(RCA)) u_chk (
    .clk(clk), .rst(rst), .start(start), .host_spi(host_spi), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg),
    .cmd_rsp_type(cmd_rsp_type), .init_done(init_done), .init_err(init_err),
    .err_code(err_code), .bus_width(bus_width), .phase(phase)
);

// File: tb/emmc_init_seq_bench.sv
module emmc_init_seq_bench;
    localparam int RMAX = 4;
    localparam int DLY  = 50;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic host_spi = 0, host_v18 = 0, host_v33 = 0, host_bus8 = 0, host_bus4 = 0, lanes8 = 0;
    logic cmd_valid, cmd_done = 0, cmd_err = 0, busy = 0;
    logic [5:0] cmd_opcode;
    logic [31:0] cmd_arg, rsp_short = 0, sector_count;
    logic [2:0] cmd_rsp_type, err_code;
    logic [127:0] rsp_long = 0;
    logic reg_byte_valid = 0;
    logic [7:0] reg_byte = 0;
    logic init_done, init_err, is_mmc, high_cap, cap_1v8, cap_3v, sig_1v8_sel;
    logic [3:0] err_step;
    logic [1:0] clk_sel, bus_width;
    logic [15:0] rca;

    emmc_init_seq #(.RETRY_MAX(RMAX), .DELAY_CYCLES(DLY)) u_emmc_init_seq (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    // card model settings
    int ready_after = 1, busy_len = 10, ocr_attempt = 0, busy_viol = 0;
    logic [5:0] err_op = 0;
    logic [31:0] ocr_val = 0, ext_sector = 0, ext_cache = 0;
    logic [127:0] csd_val = 0;
    // command log
    int n_cmd = 0;
    logic [5:0] lop [0:31];
    logic [31:0] larg [0:31];
    int lt [0:31];
    int ldone [0:31];
    logic [5:0] cur_op;
    logic [2:0] cur_rt;

    function automatic logic [7:0] ext_byte(input int i);
        if (i >= 212 && i <= 215) return ext_sector[8*(i-212) +: 8];
        if (i >= 249 && i <= 252) return ext_cache[8*(i-249) +: 8];
        return 8'hA5;
    endfunction

    task automatic serve();
        cur_op = cmd_opcode;
        cur_rt = cmd_rsp_type;
        if (n_cmd < 32) begin
            lop[n_cmd] = cmd_opcode; larg[n_cmd] = cmd_arg; lt[n_cmd] = cyc;
        end
        n_cmd++;
        repeat (2) @(negedge clk);
        cmd_done = 1;
        cmd_err  = (err_op != 0) && (cur_op == err_op);
        if (cur_op == 6'd1) begin
            ocr_attempt++;
            rsp_short = (ocr_attempt >= ready_after) ? (ocr_val | 32'h8000_0000)
                                                     : (ocr_val & 32'h7FFF_FFFF);
        end
        if (cur_op == 6'd9) rsp_long = csd_val;
        if (cur_op == 6'd2) rsp_long = 128'h1234;
        busy = (cur_rt == 3'd2) && !cmd_err;
        if (n_cmd <= 32) ldone[n_cmd-1] = cyc;
        @(negedge clk);
        cmd_done = 0;
        if (busy) begin
            repeat (busy_len) begin
                @(negedge clk);
                if (cmd_valid) busy_viol++;
            end
            busy = 0;
        end else if (cur_op == 6'd8 && !cmd_err) begin
            for (int i = 0; i < 512; i++) begin
                reg_byte_valid = 1; reg_byte = ext_byte(i);
                @(negedge clk);
            end
            reg_byte_valid = 0;
        end
        cmd_err = 0;
    endtask

    initial begin
        @(negedge clk);
        forever begin
            if (cmd_valid) serve();
            else @(negedge clk);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_once();
        int w;
        n_cmd = 0; busy_viol = 0; ocr_attempt = 0;
        start = 1; @(negedge clk); start = 0;
        w = 0;
        while (!(init_done || init_err) && w < 20000) begin @(negedge clk); w++; end
        if (w >= 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected below 20000", w);
        end
    endtask

    task automatic set_host(input logic v18, input logic v33, input logic b8, input logic b4, input logic l8);
        host_spi = 0; host_v18 = v18; host_v33 = v33; host_bus8 = b8; host_bus4 = b4; lanes8 = l8;
    endtask

    task automatic t_reset();
        chk("R12 reset done", init_done, 0);
        chk("R12 reset err", init_err, 0);
        chk("R5 reset strobe", cmd_valid, 0);
        chk("R8 reset width", bus_width, 0);
        chk("R12 reset code", err_code, 0);
    endtask

    task automatic t_spi();
        set_host(1, 1, 1, 1, 1);
        host_spi = 1;
        run_once();
        repeat (5) @(negedge clk);
        chk("R1 err", init_err, 1);
        chk("R1 code", err_code, 1);
        chk("R1 step", err_step, 0);
        chk("R1 no cmd", n_cmd, 0);
        host_spi = 0;
    endtask

    task automatic t_full();
        logic [5:0] exp_op [0:9] = '{1, 1, 1, 2, 3, 9, 7, 6, 8, 6};
        set_host(1, 1, 1, 1, 1);
        ready_after = 3; ocr_val = 32'h40FF_8080; err_op = 0; busy_len = 15;
        csd_val = 128'h0; csd_val[127:126] = 2'd3; csd_val[103:96] = 8'h32;
        ext_sector = 32'h1234_5678; ext_cache = 32'h0000_0100;
        run_once();
        chk("R5 count", n_cmd, 10);
        for (int i = 0; i < 10; i++) chk("R5 order", lop[i], exp_op[i]);
        chk("R2 ocr arg", larg[0], 32'h40FF_8080);
        chk("R5 rca arg", larg[4], 32'h0001_0000);
        chk("R5 csd arg", larg[5], 32'h0001_0000);
        chk("R8 width8 arg", larg[7], 32'h03B7_0200);
        chk("R9 cache arg", larg[9], 32'h0321_0100);
        chk("R9 sectors", sector_count, 32'h1234_5678);
        chk("R8 width", bus_width, 2);
        chk("R7 clk26", clk_sel, 2);
        chk("R4 sig18", sig_1v8_sel, 1);
        chk("R4 mmc", is_mmc, 1);
        chk("R4 hicap", high_cap, 1);
        chk("R4 cap18", cap_1v8, 1);
        chk("R4 cap3", cap_3v, 1);
        chk("R5 rca", rca, 16'h0001);
        chk("R12 done", init_done, 1);
        chk("R4 settle gap", (lt[3] - ldone[2]) >= DLY, 1);
        chk("R4 retry gap", (lt[1] - ldone[0]) >= DLY, 1);
        chk("R10 busy", busy_viol, 0);
    endtask

    task automatic t_four();
        logic [5:0] exp_op [0:6] = '{1, 2, 3, 9, 7, 6, 8};
        set_host(0, 1, 0, 1, 1);
        ready_after = 1; ocr_val = 32'h00FF_8000; busy_len = 6;
        csd_val = 128'h0; csd_val[127:126] = 2'd2; csd_val[103:96] = 8'h2A;
        ext_sector = 32'h00A0_0001; ext_cache = 0;
        run_once();
        chk("R9 count no cache", n_cmd, 7);
        for (int i = 0; i < 7; i++) chk("R5 order4", lop[i], exp_op[i]);
        chk("R2 ocr arg3v", larg[0], 32'h40FF_8000);
        chk("R8 width4 arg", larg[5], 32'h03B7_0100);
        chk("R8 width4", bus_width, 1);
        chk("R7 clk20", clk_sel, 1);
        chk("R4 no sig18", sig_1v8_sel, 0);
        chk("R4 lowcap", high_cap, 0);
        chk("R4 cap3 only", {cap_1v8, cap_3v}, 2'b01);
        chk("R9 sectors", sector_count, 32'h00A0_0001);
        chk("R10 busy4", busy_viol, 0);
    endtask

    task automatic t_one();
        logic [5:0] exp_op [0:5] = '{1, 2, 3, 9, 7, 8};
        set_host(1, 0, 0, 0, 0);
        ready_after = 1; ocr_val = 32'h40FF_8000;
        csd_val = 128'h0; csd_val[127:126] = 2'd3; csd_val[103:96] = 8'h11;
        run_once();
        chk("R8 count skip", n_cmd, 6);
        for (int i = 0; i < 6; i++) chk("R8 order1", lop[i], exp_op[i]);
        chk("R2 ocr arg18", larg[0], 32'h4000_0080);
        chk("R8 width1", bus_width, 0);
        chk("R7 clkslow", clk_sel, 0);
        chk("R4 card no 18", sig_1v8_sel, 0);
        chk("R4 hicap1", high_cap, 1);
    endtask

    task automatic t_lanes();
        set_host(0, 1, 1, 1, 0);
        run_once();
        chk("R8 lanes arg", larg[5], 32'h03B7_0100);
        chk("R8 lanes width", bus_width, 1);
    endtask

    task automatic t_legacy();
        set_host(0, 1, 0, 1, 1);
        csd_val = 128'h0; csd_val[127:126] = 2'd1;
        run_once();
        chk("R6 code", err_code, 4);
        chk("R6 step", err_step, 4);
        chk("R6 count", n_cmd, 4);
        chk("R6 last op", lop[3], 9);
        chk("R12 no done", init_done, 0);
    endtask

    task automatic t_timeout();
        csd_val[127:126] = 2'd3;
        ready_after = 99;
        run_once();
        chk("R3 count", n_cmd, RMAX);
        for (int i = 0; i < RMAX; i++) chk("R3 op", lop[i], 1);
        chk("R3 code", err_code, 3);
        chk("R3 step", err_step, 1);
        chk("R4 mmc on poll", is_mmc, 1);
        ready_after = 1;
    endtask

    task automatic t_cmderr();
        err_op = 6'd3;
        run_once();
        repeat (30) @(negedge clk);
        chk("R11 code", err_code, 2);
        chk("R11 step", err_step, 3);
        chk("R11 stopped", n_cmd, 3);
        chk("R12 held", init_err, 1);
        err_op = 6'd6;
        run_once();
        chk("R11 width step", err_step, 7);
        err_op = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_spi();
        t_full();
        t_four();
        t_one();
        t_lanes();
        t_legacy();
        t_timeout();
        t_cmderr();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1900000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule